// File: doc/BRIEF.md
# Burst column sequencer

This block steps through the column addresses of one SDRAM read or write burst and gives one column per clock. A controller strobes `start` with the first column, a length code and an ordering bit. From the next clock on, the block presents each column of the burst on `col` with `valid` high. It raises `last` on the final beat of a fixed-length burst.

Fixed bursts of 1, 2, 4 or 8 beats stay inside the aligned block of that size that holds the start column. In linear order the low bits count up and wrap inside that block. In interleaved order the low bits are the start column XOR the beat index. The full-page length walks the whole 256-column row in ascending order and keeps going until `stop` ends it. `stop` can also cut a fixed burst short. A `start` that arrives during a burst drops the old sequence and begins the new one.

Top module: `burst_col_seq`

## Requirements
- R1: While `rst_n` is low, and on every cycle afterwards with `valid` low, `valid` and `last` are 0 and `col` is 0.
- R2: A `start` sampled on a rising edge makes `valid` high after that edge, with `col` equal to the sampled `start_col`. Each later edge advances one beat.
- R3: `len_code` sets the burst length: 0 gives 1 beat, 1 gives 2, 2 gives 4, 3 gives 8, and 7 gives full page. Codes 4, 5 and 6 give a 1-beat burst.
- R4: `interleave` = 0 selects linear order. For a fixed length N, beat k has low log2(N) bits equal to (start + k) mod N, and the upper bits equal those of the start column.
- R5: `interleave` = 1 selects interleaved order. For a fixed length N, beat k has `col` = start XOR k.
- R6: In full-page mode beat k has `col` = (start + k) mod 256. The column wraps from 255 to 0, the burst continues and `last` never asserts.
- R7: In a fixed burst `last` is high exactly on beat N-1. On the following cycle `valid` is low unless a new start was sampled.
- R8: A `stop` sampled during a burst makes `valid` low after that edge. `stop` has no effect while idle. When `start` and `stop` are sampled together, the start takes effect.
- R9: A `start` sampled during a burst, including on its last beat, restarts the sequence at the new column with the new length and order.
- R10: In full-page mode the `interleave` bit is ignored and the order is always ascending.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Synchronous active-low reset |
| start | input | 1 | Begin a burst with the inputs below |
| start_col | input | 8 | First column of the burst |
| len_code | input | 3 | Burst length code |
| interleave | input | 1 | 1 selects interleaved order, 0 selects linear |
| stop | input | 1 | End the running burst |
| col | output | 8 | Current column |
| valid | output | 1 | A burst beat is present on `col` |
| last | output | 1 | Final beat of a fixed-length burst |

## Verification
Beat 0 of a burst appears one rising edge after `start` is sampled, and each later beat one edge after the one before. `valid` drops on the edge that samples `stop` or that follows the `last` beat. The driver changes inputs on falling edges and queues the exact expected column and `last` flag for every beat when it issues the start. The monitor samples 1 ns after each rising edge and pops one expected item for each beat where `valid` is high, so every beat is compared in the cycle it is due. A stray, missing or late beat shows up as a queue mismatch, or as a non-empty queue at the idle check that follows each burst.

// File: rtl/burst_col_seq.sv
module burst_col_seq #(
  parameter int COL_W = 8,
  parameter int CODE_W = 3,
  parameter logic [CODE_W-1:0] FULL_CODE = '1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start,
  input  logic [COL_W-1:0]  start_col,
  input  logic [CODE_W-1:0] len_code,
  input  logic              interleave,
  input  logic              stop,
  output logic [COL_W-1:0]  col,
  output logic              valid,
  output logic              last
);

  logic             run_q, full_q, ilv_q;
  logic [COL_W-1:0] base_q, beat_q, mask_q;
  logic [COL_W-1:0] mask_d, lin_col, ilv_col;
  logic             full_d, end_beat;

  assign full_d = (len_code == FULL_CODE);

  always_comb begin
    mask_d = '0;
    if (full_d)                  mask_d = '1;
    else if (len_code == 1)      mask_d = COL_W'(1);
    else if (len_code == 2)      mask_d = COL_W'(3);
    else if (len_code == 3)      mask_d = COL_W'(7);
  end

  assign end_beat = run_q & ~full_q & (beat_q == mask_q);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      run_q  <= 1'b0;
      full_q <= 1'b0;
      ilv_q  <= 1'b0;
      base_q <= '0;
      beat_q <= '0;
      mask_q <= '0;
    end else if (start) begin
      run_q  <= 1'b1;
      full_q <= full_d;
      ilv_q  <= interleave & ~full_d;
      base_q <= start_col;
      beat_q <= '0;
      mask_q <= mask_d;
    end else if (run_q) begin
      if (stop || end_beat) run_q <= 1'b0;
      else                  beat_q <= beat_q + 1'b1;
    end
  end

  assign lin_col = (base_q & ~mask_q) | ((base_q + beat_q) & mask_q);
  assign ilv_col = base_q ^ beat_q;

  assign col   = run_q ? (ilv_q ? ilv_col : lin_col) : '0;
  assign valid = run_q;
  assign last  = end_beat;

endmodule

// File: rtl/burst_col_seq_chk.sv
module burst_col_seq_chk #(
  parameter int COL_W = 8,
  parameter int CODE_W = 3
) (
  input logic              clk,
  input logic              rst_n,
  input logic              start,
  input logic [COL_W-1:0]  start_col,
  input logic [CODE_W-1:0] len_code,
  input logic              stop,
  input logic [COL_W-1:0]  col,
  input logic              valid,
  input logic              last
);

  logic             full_q;
  logic [COL_W-1:0] mask_q;
  logic [COL_W-1:0] mask_d;

  always_comb begin
    mask_d = '0;
    if (len_code == 1)      mask_d = COL_W'(1);
    else if (len_code == 2) mask_d = COL_W'(3);
    else if (len_code == 3) mask_d = COL_W'(7);
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      full_q <= 1'b0;
      mask_q <= '0;
    end else if (start) begin
      full_q <= (len_code == '1);
      mask_q <= mask_d;
    end
  end

  AST_IDLE_ZERO: assert property (@(posedge clk) disable iff (!rst_n) !valid |-> (col == '0 && !last)); // R1
  AST_START_LOAD: assert property (@(posedge clk) disable iff (!rst_n) start |=> (valid && col == $past(start_col))); // R2
  AST_ONE_BEAT: assert property (@(posedge clk) disable iff (!rst_n) (valid && !full_q && mask_q == '0) |-> last); // R3
  AST_UPPER_FIXED: assert property (@(posedge clk) disable iff (!rst_n) (valid && !full_q && !start && !stop && !last) |=> ((col & ~mask_q) == ($past(col) & ~mask_q))); // R4
  AST_FULL_NO_LAST: assert property (@(posedge clk) disable iff (!rst_n) (valid && full_q) |-> !last); // R6
  AST_FULL_STEP: assert property (@(posedge clk) disable iff (!rst_n) (valid && full_q && !start && !stop) |=> (valid && col == COL_W'($past(col) + 1'b1))); // R10
  AST_LAST_ENDS: assert property (@(posedge clk) disable iff (!rst_n) (last && !start) |=> !valid); // R7
  AST_STOP_ENDS: assert property (@(posedge clk) disable iff (!rst_n) (stop && !start) |=> !valid); // R8

endmodule

bind burst_col_seq burst_col_seq_chk #(.COL_W(COL_W), .CODE_W(CODE_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .start(start), .start_col(start_col),
  .len_code(len_code), .stop(stop), .col(col), .valid(valid), .last(last)
);

// File: tb/burst_col_seq_tb.sv
module burst_col_seq_tb;

  typedef struct {
    logic [7:0] c;
    logic       l;
    string      tag;
  } item_t;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       start = 1'b0;
  logic [7:0] start_col = '0;
  logic [2:0] len_code = '0;
  logic       interleave = 1'b0;
  logic       stop = 1'b0;
  logic [7:0] col;
  logic       valid, last;

  int    n_chk = 0;
  int    n_bad = 0;
  bit    done = 0;
  item_t q[$];

  always #2 clk = ~clk;

  burst_col_seq u_dut (
    .clk(clk), .rst_n(rst_n), .start(start), .start_col(start_col),
    .len_code(len_code), .interleave(interleave), .stop(stop),
    .col(col), .valid(valid), .last(last)
  );

  function automatic int beats_of(logic [2:0] code);
    case (code)
      3'd1: return 2;
      3'd2: return 4;
      3'd3: return 8;
      3'd7: return 256;
      default: return 1;
    endcase
  endfunction

  function automatic logic [7:0] exp_col(logic [7:0] s, logic [2:0] code, logic ilv, int k);
    logic [7:0] m;
    m = 8'(beats_of(code) - 1);
    if (code == 3'd7) return 8'(s + k);
    if (ilv) return s ^ 8'(k);
    return (s & ~m) | (8'(s + k) & m);
  endfunction

  task automatic push_seq(logic [7:0] s, logic [2:0] code, logic ilv, int n, string tag);
    for (int k = 0; k < n; k++) begin
      item_t it;
      it.c = exp_col(s, code, ilv, k);
      it.l = (code != 3'd7) && (k == beats_of(code) - 1);
      it.tag = tag;
      q.push_back(it);
    end
  endtask

  task automatic check(bit ok, string tag, string what, int act, int exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s %s actual=%0h expected=%0h", tag, what, act, exp);
    end
  endtask

  task automatic idle_check(string tag);
    check(!valid && !last && col == 8'h00, tag, "idle outputs {valid,last,col}",
          {valid, last, col}, 0);
    check(q.size() == 0, tag, "beats still pending", q.size(), 0);
  endtask

  // nb beats; stop asserted while beat nb-1 is shown when use_stop
  task automatic burst(logic [7:0] s, logic [2:0] code, logic ilv, int nb, bit use_stop, string tag);
    start = 1'b1; start_col = s; len_code = code; interleave = ilv;
    push_seq(s, code, ilv, nb, tag);
    @(negedge clk);
    start = 1'b0;
    repeat (nb - 1) @(negedge clk);
    if (use_stop) begin
      stop = 1'b1;
      @(negedge clk);
      stop = 1'b0;
    end else begin
      @(negedge clk);
    end
    idle_check(tag);
  endtask

  always @(posedge clk) begin
    #1;
    if (rst_n && valid) begin
      if (q.size() == 0) begin
        check(1'b0, "R7", "unexpected beat col", col, 0);
      end else begin
        item_t it;
        it = q.pop_front();
        check(col == it.c, it.tag, "col", col, it.c);
        check(last == it.l, it.tag, "last", last, it.l);
      end
    end
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      done = 1;
      n_chk++; n_bad++;
      $display("FAIL watchdog expired actual=1 expected=0");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    check(!valid && !last && col == 8'h00, "R1", "reset outputs", {valid, last, col}, 0);
    rst_n = 1'b1;
    @(negedge clk);
    idle_check("R1");

    burst(8'h2D, 3'd2, 1'b0, 4, 1'b0, "R4");   // 2D 2E 2F 2C
    burst(8'h13, 3'd3, 1'b0, 8, 1'b0, "R4");   // 13..17 10 11 12
    burst(8'h13, 3'd3, 1'b1, 8, 1'b0, "R5");   // 13 12 11 10 17 16 15 14
    burst(8'hFF, 3'd1, 1'b1, 2, 1'b0, "R5");   // FF FE
    burst(8'h5A, 3'd0, 1'b0, 1, 1'b0, "R3");
    burst(8'h77, 3'd5, 1'b1, 1, 1'b0, "R3");   // reserved code -> 1 beat
    burst(8'h81, 3'd1, 1'b0, 2, 1'b0, "R7");
    burst(8'hFC, 3'd7, 1'b1, 7, 1'b1, "R10");  // FC FD FE FF 00 01 02
    burst(8'h00, 3'd7, 1'b0, 300, 1'b1, "R6"); // wraps past 255
    burst(8'h46, 3'd3, 1'b0, 3, 1'b1, "R8");   // 46 47 40 then stop

    // stop while idle has no effect
    stop = 1'b1;
    @(negedge clk);
    @(negedge clk);
    stop = 1'b0;
    idle_check("R8");

    // start and stop together: start wins
    start = 1'b1; stop = 1'b1; start_col = 8'h9B; len_code = 3'd2; interleave = 1'b1;
    push_seq(8'h9B, 3'd2, 1'b1, 4, "R8");
    @(negedge clk);
    start = 1'b0; stop = 1'b0;
    repeat (4) @(negedge clk);
    idle_check("R8");

    // restart during a burst
    start = 1'b1; start_col = 8'h40; len_code = 3'd3; interleave = 1'b0;
    push_seq(8'h40, 3'd3, 1'b0, 8, "R9");
    @(negedge clk);
    start = 1'b0;
    @(negedge clk);
    q.delete();
    start = 1'b1; start_col = 8'h85; len_code = 3'd2; interleave = 1'b0;
    push_seq(8'h85, 3'd2, 1'b0, 4, "R9");        // 85 86 87 84
    @(negedge clk);
    start = 1'b0;
    repeat (4) @(negedge clk);
    idle_check("R9");

    // restart on the last beat
    start = 1'b1; start_col = 8'h10; len_code = 3'd1; interleave = 1'b0;
    push_seq(8'h10, 3'd1, 1'b0, 2, "R9");
    @(negedge clk);
    start = 1'b0;
    @(negedge clk);
    check(last == 1'b1, "R7", "last on final beat", last, 1);
    start = 1'b1; start_col = 8'h33; len_code = 3'd0;
    push_seq(8'h33, 3'd0, 1'b0, 1, "R9");
    @(negedge clk);
    start = 1'b0;
    @(negedge clk);
    idle_check("R9");

    if (!done) begin
      done = 1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end

endmodule